// File: doc/BRIEF.md
# Multimode Pixel Input Capture Demultiplexer

This block sits at the pixel input of a video output pipeline. It receives three 8-bit buses and turns the incoming 4:2:2 stream into luma/chroma groups. Each group holds two luma samples and the blue-difference and red-difference samples that those two samples share. A group is presented with a one-cycle valid strobe. There are two output paths. The standard-definition path takes one interleaved single-rate byte stream. The enhanced/high-definition path accepts any of three inputs:
- luma and chroma on separate buses at single rate;
- luma and chroma on one bus, one sample on each clock edge;
- an interleaved stream on one bus at a doubled clock.

A 3-bit mode code enables one path or both together. A 2-bit edge code picks which clock edge carries luma in the dual-edge input. A swap control moves the standard-definition stream from its own bus to the luma bus. An alignment input restarts chroma ordering, so that the sample taken with it is a blue-difference sample. Reserved mode codes are reported on an error output, and so are reserved edge codes while a dual-edge mode is selected. While the error output is set, all output strobes are held low.

Top module: `pix_cap_demux`

## Requirements
- R1: The SD path produces groups only in modes 000, 011 and 100. The HD path produces groups only in modes 001, 010, 011, 100 and 111.
- R2: Mode codes 101 and 110 set `cfg_err` and keep `sd_valid` and `hd_valid` low.
- R3: In modes 010 and 100, edge codes 01 and 10 set `cfg_err` and keep both valid outputs low. In all other modes the edge code has no effect on `cfg_err` or on the output data.
- R4: On the SD path, bytes arrive in a four-cycle order: blue-diff, luma0, red-diff, luma1. `sd_valid` is high for one cycle, in the cycle after the edge that samples luma1, and the group fields carry those four bytes.
- R5: A byte sampled with `align` high is taken as the blue-difference byte that starts a group, whatever the phase was before. Neither valid output is high in the cycle after such an edge.
- R6: With `sd_bus_swap`=1 the SD stream is read from `bus_y`, and with `sd_bus_swap`=0 it is read from `bus_s`. The swap has no effect on HD output.
- R7: In modes 001 and 011, each rising edge samples luma on `bus_y` and chroma on `bus_c`. Chroma alternates blue-diff then red-diff from alignment. `hd_valid` pulses after every second edge with {luma0, luma1, blue-diff, red-diff}.
- R8: In modes 010 and 100 with edge code 00, `bus_y` is sampled on both edges. The falling-edge byte is luma and the following rising-edge byte is chroma. The two leave together and are grouped as in R7.
- R9: With edge code 11 in modes 010 and 100, the rising-edge byte is luma and the preceding falling-edge byte is chroma.
- R10: In mode 111, `bus_y` carries an interleaved stream in the order of R4. It is output on the HD path at one group per four cycles.
- R11: During reset (synchronous, active high) both valid outputs are low and all group fields are zero.
- R12: In modes 011 and 100 both paths run at once, each from its own buses and with its own group rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Input mode code |
| edge_sel | input | 2 | Dual-edge luma/chroma edge code |
| sd_bus_swap | input | 1 | SD stream taken from bus_y when 1 |
| align | input | 1 | Restart chroma ordering at this sample |
| bus_y | input | 8 | Luma / dual-edge / doubled-clock bus |
| bus_c | input | 8 | HD chroma bus |
| bus_s | input | 8 | SD bus |
| sd_valid | output | 1 | SD group strobe |
| sd_y0 | output | 8 | SD first luma |
| sd_y1 | output | 8 | SD second luma |
| sd_cb | output | 8 | SD blue-difference |
| sd_cr | output | 8 | SD red-difference |
| hd_valid | output | 1 | HD group strobe |
| hd_y0 | output | 8 | HD first luma |
| hd_y1 | output | 8 | HD second luma |
| hd_cb | output | 8 | HD blue-difference |
| hd_cr | output | 8 | HD red-difference |
| cfg_err | output | 1 | Reserved mode or edge code selected |

## Verification
The hardest case to reach from the ports is the dual-edge input. There, the falling-edge byte must pair with the rising edge that follows it, and the edge code decides which byte becomes luma. The stimulus drives `bus_y` twice per clock period: one value set up before each falling edge and another before each rising edge. It does this for both legal edge codes, and again with a second bus active in the simultaneous mode. A second hard case is a realignment in the middle of a group, after a partial group has already been sampled. The stimulus feeds two stray bytes before an aligned block and checks that the first group comes out whole.

// File: rtl/pix_cap_pkg.sv
package pix_cap_pkg;

    parameter int unsigned PIX_W = 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        pix_t y0;
        pix_t y1;
        pix_t cb;
        pix_t cr;
    } grp_t;

    localparam logic [2:0] MD_SD        = 3'b000;
    localparam logic [2:0] MD_HD_SDR    = 3'b001;
    localparam logic [2:0] MD_HD_DDR    = 3'b010;
    localparam logic [2:0] MD_DUAL_SDR  = 3'b011;
    localparam logic [2:0] MD_DUAL_DDR  = 3'b100;
    localparam logic [2:0] MD_ED_DBLCLK = 3'b111;

    localparam logic [1:0] EDGE_LUMA_FALL = 2'b00;
    localparam logic [1:0] EDGE_LUMA_RISE = 2'b11;

    function automatic logic mode_reserved(input logic [2:0] m);
        return (m == 3'b101) || (m == 3'b110);
    endfunction

    function automatic logic mode_has_sd(input logic [2:0] m);
        return (m == MD_SD) || (m == MD_DUAL_SDR) || (m == MD_DUAL_DDR);
    endfunction

    function automatic logic mode_is_ddr(input logic [2:0] m);
        return (m == MD_HD_DDR) || (m == MD_DUAL_DDR);
    endfunction

    function automatic logic mode_is_split(input logic [2:0] m);
        return (m == MD_HD_SDR) || (m == MD_DUAL_SDR);
    endfunction

    function automatic logic edge_reserved(input logic [1:0] e);
        return (e != EDGE_LUMA_FALL) && (e != EDGE_LUMA_RISE);
    endfunction

endpackage

// File: rtl/pix_ilv_unpack.sv
module pix_ilv_unpack
    import pix_cap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic align,
    input  pix_t din,
    output grp_t grp,
    output logic grp_valid
);
    localparam int unsigned SLOTS = 4;
    localparam int unsigned PH_W  = $clog2(SLOTS);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] cur_ph;
    pix_t            cb_h, y0_h, cr_h;

    assign cur_ph = align ? '0 : ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= '0;
            cb_h      <= '0;
            y0_h      <= '0;
            cr_h      <= '0;
            grp       <= '0;
            grp_valid <= 1'b0;
        end else if (!en) begin
            ph_q      <= '0;
            grp_valid <= 1'b0;
        end else begin
            ph_q      <= cur_ph + PH_W'(1);
            grp_valid <= (cur_ph == PH_W'(SLOTS-1));
            case (cur_ph)
                PH_W'(0): cb_h <= din;
                PH_W'(1): y0_h <= din;
                PH_W'(2): cr_h <= din;
                default:  grp  <= '{y0: y0_h, y1: din, cb: cb_h, cr: cr_h};
            endcase
        end
    end
endmodule

// File: rtl/pix_split_pair.sv
module pix_split_pair
    import pix_cap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic align,
    input  pix_t luma,
    input  pix_t chroma,
    output grp_t grp,
    output logic grp_valid
);
    logic ph_q;
    logic cur_ph;
    pix_t y0_h, cb_h;

    assign cur_ph = align ? 1'b0 : ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= 1'b0;
            y0_h      <= '0;
            cb_h      <= '0;
            grp       <= '0;
            grp_valid <= 1'b0;
        end else if (!en) begin
            ph_q      <= 1'b0;
            grp_valid <= 1'b0;
        end else begin
            ph_q      <= ~cur_ph;
            grp_valid <= cur_ph;
            if (!cur_ph) begin
                y0_h <= luma;
                cb_h <= chroma;
            end else begin
                grp <= '{y0: y0_h, y1: luma, cb: cb_h, cr: chroma};
            end
        end
    end
endmodule

// File: rtl/pix_ddr_lanes.sv
module pix_ddr_lanes
    import pix_cap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic luma_on_rise,
    input  pix_t din,
    output pix_t luma,
    output pix_t chroma
);
    pix_t fall_q;

    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= din;
    end

    assign luma   = luma_on_rise ? din    : fall_q;
    assign chroma = luma_on_rise ? fall_q : din;
endmodule

// File: rtl/pix_cap_demux.sv
module pix_cap_demux
    import pix_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_sel,
    input  logic [1:0]       edge_sel,
    input  logic             sd_bus_swap,
    input  logic             align,
    input  logic [PIX_W-1:0] bus_y,
    input  logic [PIX_W-1:0] bus_c,
    input  logic [PIX_W-1:0] bus_s,
    output logic             sd_valid,
    output logic [PIX_W-1:0] sd_y0,
    output logic [PIX_W-1:0] sd_y1,
    output logic [PIX_W-1:0] sd_cb,
    output logic [PIX_W-1:0] sd_cr,
    output logic             hd_valid,
    output logic [PIX_W-1:0] hd_y0,
    output logic [PIX_W-1:0] hd_y1,
    output logic [PIX_W-1:0] hd_cb,
    output logic [PIX_W-1:0] hd_cr,
    output logic             cfg_err
);
    logic is_ddr, sd_en, split_en, dbl_en;
    pix_t sd_src, ddr_luma, ddr_chroma, sp_luma, sp_chroma;
    grp_t sd_grp, sp_grp, dbl_grp, hd_grp;
    logic sd_v, sp_v, dbl_v;

    assign is_ddr   = mode_is_ddr(mode_sel);
    assign cfg_err  = mode_reserved(mode_sel) | (is_ddr & edge_reserved(edge_sel));
    assign sd_en    = mode_has_sd(mode_sel) & ~cfg_err;
    assign split_en = (mode_is_split(mode_sel) | is_ddr) & ~cfg_err;
    assign dbl_en   = (mode_sel == MD_ED_DBLCLK) & ~cfg_err;

    assign sd_src = sd_bus_swap ? bus_y : bus_s;

    pix_ilv_unpack u_sd (
        .clk(clk), .rst(rst), .en(sd_en), .align(align),
        .din(sd_src), .grp(sd_grp), .grp_valid(sd_v)
    );

    pix_ddr_lanes u_ddr (
        .clk(clk), .rst(rst), .luma_on_rise(edge_sel == EDGE_LUMA_RISE),
        .din(bus_y), .luma(ddr_luma), .chroma(ddr_chroma)
    );

    assign sp_luma   = is_ddr ? ddr_luma   : bus_y;
    assign sp_chroma = is_ddr ? ddr_chroma : bus_c;

    pix_split_pair u_split (
        .clk(clk), .rst(rst), .en(split_en), .align(align),
        .luma(sp_luma), .chroma(sp_chroma), .grp(sp_grp), .grp_valid(sp_v)
    );

    pix_ilv_unpack u_dbl (
        .clk(clk), .rst(rst), .en(dbl_en), .align(align),
        .din(bus_y), .grp(dbl_grp), .grp_valid(dbl_v)
    );

    assign hd_grp   = dbl_en ? dbl_grp : sp_grp;
    assign sd_valid = sd_v & sd_en;
    assign hd_valid = (sp_v & split_en) | (dbl_v & dbl_en);

    assign sd_y0 = sd_grp.y0;
    assign sd_y1 = sd_grp.y1;
    assign sd_cb = sd_grp.cb;
    assign sd_cr = sd_grp.cr;
    assign hd_y0 = hd_grp.y0;
    assign hd_y1 = hd_grp.y1;
    assign hd_cb = hd_grp.cb;
    assign hd_cr = hd_grp.cr;
endmodule

// File: rtl/pix_cap_demux_chk.sv
module pix_cap_demux_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_sel,
    input logic [1:0] edge_sel,
    input logic       align,
    input logic       sd_valid,
    input logic       hd_valid,
    input logic       cfg_err
);
    logic ddr_mode, rsvd_mode, rsvd_edge;
    assign ddr_mode  = (mode_sel == 3'b010) || (mode_sel == 3'b100);
    assign rsvd_mode = (mode_sel == 3'b101) || (mode_sel == 3'b110);
    assign rsvd_edge = (edge_sel == 2'b01) || (edge_sel == 2'b10);

    AST_RSVD_MODE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        rsvd_mode |-> (cfg_err && !sd_valid && !hd_valid)); // R2
    AST_RSVD_EDGE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (ddr_mode && rsvd_edge) |-> (cfg_err && !sd_valid && !hd_valid)); // R3
    AST_EDGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!ddr_mode && !rsvd_mode) |-> !cfg_err); // R3
    AST_SD_PATH_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 3'b001 || mode_sel == 3'b010 || mode_sel == 3'b111) |-> !sd_valid); // R1
    AST_HD_PATH_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 3'b000) |-> !hd_valid); // R1
    AST_SD_GROUP_GAP: assert property (@(posedge clk) disable iff (rst)
        sd_valid |=> !sd_valid); // R4
    AST_HD_GROUP_GAP: assert property (@(posedge clk) disable iff (rst)
        hd_valid |=> !hd_valid); // R7
    AST_ALIGN_RESTART: assert property (@(posedge clk) disable iff (rst)
        align |=> (!sd_valid && !hd_valid)); // R5
endmodule

bind pix_cap_demux pix_cap_demux_chk u_chk (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .edge_sel(edge_sel),
    .align(align), .sd_valid(sd_valid), .hd_valid(hd_valid), .cfg_err(cfg_err)
);

// File: tb/pix_cap_demux_tb.sv
module pix_cap_demux_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_sel = 3'b000;
    logic [1:0] edge_sel = 2'b00;
    logic       sd_bus_swap = 1'b0;
    logic       align = 1'b0;
    logic [7:0] bus_y = '0, bus_c = '0, bus_s = '0;
    logic       sd_valid, hd_valid, cfg_err;
    logic [7:0] sd_y0, sd_y1, sd_cb, sd_cr, hd_y0, hd_y1, hd_cb, hd_cr;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pix_cap_demux u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .edge_sel(edge_sel),
        .sd_bus_swap(sd_bus_swap), .align(align),
        .bus_y(bus_y), .bus_c(bus_c), .bus_s(bus_s),
        .sd_valid(sd_valid), .sd_y0(sd_y0), .sd_y1(sd_y1), .sd_cb(sd_cb), .sd_cr(sd_cr),
        .hd_valid(hd_valid), .hd_y0(hd_y0), .hd_y1(hd_y1), .hd_cb(hd_cb), .hd_cr(hd_cr),
        .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_err(input logic [2:0] m, input logic [1:0] e);
        logic ddr = (m == 3'b010) || (m == 3'b100);
        return (m == 3'b101) || (m == 3'b110) || (ddr && (e == 2'b01 || e == 2'b10));
    endfunction

    // entered at posedge+2; returns at posedge+2 after the edge that sampled the step
    task automatic step(input logic [7:0] yf, input logic [7:0] yr, input logic [7:0] c,
                        input logic [7:0] s, input logic al);
        bus_y = yf;
        #4;
        bus_y = yr; bus_c = c; bus_s = s; align = al;
        @(posedge clk); #2;
    endtask

    task automatic run_blocks(input string tag, input logic [2:0] m, input logic [1:0] e,
                              input logic sw, input int nblk);
        logic err, sd_on, split_on, dbl_on, ddr;
        mode_sel = m; edge_sel = e; sd_bus_swap = sw;
        err      = exp_err(m, e);
        ddr      = (m == 3'b010) || (m == 3'b100);
        sd_on    = !err && (m == 3'b000 || m == 3'b011 || m == 3'b100);
        split_on = !err && (m == 3'b001 || m == 3'b011 || ddr);
        dbl_on   = !err && (m == 3'b111);
        for (int b = 0; b < nblk; b++) begin
            logic [7:0] sdb[4];
            logic [7:0] ga[4];
            logic [7:0] gb[4];
            for (int i = 0; i < 4; i++) begin
                sdb[i] = 8'($urandom); ga[i] = 8'($urandom); gb[i] = 8'($urandom);
            end
            // ga/gb fields: [0]=y0 [1]=y1 [2]=cb [3]=cr
            for (int k = 0; k < 4; k++) begin
                logic [7:0] lu, ch, ilv, yf, yr, sb;
                logic sd_ev, hd_ev;
                lu  = (k == 0) ? ga[0] : (k == 1) ? ga[1] : (k == 2) ? gb[0] : gb[1];
                ch  = (k == 0) ? ga[2] : (k == 1) ? ga[3] : (k == 2) ? gb[2] : gb[3];
                ilv = (k == 0) ? ga[2] : (k == 1) ? ga[0] : (k == 2) ? ga[3] : ga[1];
                if (m == 3'b111)      begin yf = ilv; yr = ilv; end
                else if (ddr)         begin
                    if (e == 2'b11) begin yf = ch; yr = lu; end
                    else            begin yf = lu; yr = ch; end
                end
                else if (m == 3'b001 || m == 3'b011) begin yf = lu; yr = lu; end
                else if (sw)          begin yf = sdb[k]; yr = sdb[k]; end
                else                  begin yf = 8'($urandom); yr = yf; end
                sb = sw ? 8'($urandom) : sdb[k];
                step(yf, yr, ch, sb, (b == 0) && (k == 0));
                sd_ev = sd_on && (k == 3);
                hd_ev = (split_on && (k == 1 || k == 3)) || (dbl_on && k == 3);
                chk(tag, "sd_valid", 32'(sd_valid), 32'(sd_ev));
                chk(tag, "hd_valid", 32'(hd_valid), 32'(hd_ev));
                if (sd_ev)
                    chk(tag, "sd group", {sd_y0, sd_y1, sd_cb, sd_cr},
                        {sdb[1], sdb[3], sdb[0], sdb[2]});
                if (hd_ev) begin
                    if (split_on && k == 3)
                        chk(tag, "hd group", {hd_y0, hd_y1, hd_cb, hd_cr}, {gb[0], gb[1], gb[2], gb[3]});
                    else
                        chk(tag, "hd group", {hd_y0, hd_y1, hd_cb, hd_cr}, {ga[0], ga[1], ga[2], ga[3]});
                end
            end
            chk(tag, "cfg_err", 32'(cfg_err), 32'(err));
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        // R11: reset state
        chk("R11", "valids in reset", {30'd0, sd_valid, hd_valid}, 32'd0);
        chk("R11", "fields in reset", {sd_y0, sd_y1, sd_cb, sd_cr} | {hd_y0, hd_y1, hd_cb, hd_cr}, 32'd0);
        rst = 1'b0;

        run_blocks("R4", 3'b000, 2'b00, 1'b0, 6);
        run_blocks("R6", 3'b000, 2'b00, 1'b1, 4);
        // R5: realign after a partial group
        step(8'h11, 8'h11, 8'h22, 8'h33, 1'b1);
        step(8'h44, 8'h44, 8'h55, 8'h66, 1'b0);
        run_blocks("R5", 3'b000, 2'b00, 1'b0, 2);
        step(8'h77, 8'h77, 8'h88, 8'h99, 1'b1);
        run_blocks("R5", 3'b001, 2'b00, 1'b0, 2);

        run_blocks("R7", 3'b001, 2'b00, 1'b0, 5);
        run_blocks("R6", 3'b001, 2'b00, 1'b1, 3);
        run_blocks("R8", 3'b010, 2'b00, 1'b0, 5);
        run_blocks("R9", 3'b010, 2'b11, 1'b0, 5);
        run_blocks("R10", 3'b111, 2'b00, 1'b0, 4);
        run_blocks("R12", 3'b011, 2'b00, 1'b0, 4);
        run_blocks("R12", 3'b100, 2'b00, 1'b0, 3);
        run_blocks("R12", 3'b100, 2'b11, 1'b0, 3);
        run_blocks("R2", 3'b101, 2'b00, 1'b0, 2);
        run_blocks("R2", 3'b110, 2'b11, 1'b0, 2);
        run_blocks("R3", 3'b010, 2'b01, 1'b0, 2);
        run_blocks("R3", 3'b100, 2'b10, 1'b0, 2);
        run_blocks("R3", 3'b001, 2'b01, 1'b0, 3);
        run_blocks("R3", 3'b000, 2'b10, 1'b0, 3);
        run_blocks("R1", 3'b000, 2'b00, 1'b0, 2);
        run_blocks("R1", 3'b111, 2'b00, 1'b0, 2);
        run_blocks("R8", 3'b010, 2'b00, 1'b0, 2);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule